// File: doc/BRIEF.md
# Lane-parallel Q15 Rounding Multiply-High Unit

This block multiplies several pairs of signed 16-bit fractional values (one sign bit, fifteen fraction bits) at once. Each result is the rounded upper half of the full product. One beat carries a word of `LANES` operand pairs and a mode bit. The block registers the results, so they appear one clock after the beat is accepted. Image and signal pipelines use it after they have widened their samples to 16 bits.

Two interpretations of the most negative code are supported. In signed mode, code 0x8000 means −1.0. A −1.0 × −1.0 product cannot be represented. By default it wraps to 0x8000. A build-time parameter can clamp it to 0x7FFF instead.

In magnitude mode, the caller promises that both operands are non-negative values in the range 0x0000..0x8000, and 0x8000 stands for +1.0. The block then returns the absolute value of the signed result. The absolute value of 0x8000 stays 0x8000, which here reads as +1.0. The mode travels with each beat, so successive beats may use different modes.

Top module: `q15_mulhr_array`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `out_valid` is 0 and `out_y` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high, so the latency is one clock.
- R3: In signed mode (`in_mode`=0), each 16-bit lane k of `out_y` (bits 16k+15..16k) equals the low 16 bits of floor((a×b + 16384) / 32768). Here a and b are lane k of `in_a` and `in_b`, read as two's complement. Lanes do not affect one another, and a zero operand always gives 0x0000.
- R4: In signed mode, 0x8000 × 0x4000 gives 0xC000 (−0.5), and 0x7FFF × 0x7FFF gives 0x7FFE.
- R5: In signed mode, 0x8000 × 0x8000 gives 0x8000 with the default `SAT_SQ`=0, and 0x7FFF with `SAT_SQ`=1.
- R6: In magnitude mode (`in_mode`=1), each lane is the absolute value of the signed-mode result, so 0x8000 × 0x4000 gives 0x4000 (+0.5). No lane result is ever a negative code other than 0x8000.
- R7: In magnitude mode, a signed-mode result of 0x8000 stays 0x8000, so 0x8000 × 0x8000 gives 0x8000 (+1.0) for either setting of `SAT_SQ`.
- R8: The mode is captured with the operands of the same beat, so beats sent back to back with different modes each follow their own mode.
- R9: In a cycle where `in_valid` is low, `out_y` keeps its previous value, whatever `in_a`, `in_b` and `in_mode` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the inputs this cycle |
| in_mode | input | 1 | 0 = signed (0x8000 is −1.0), 1 = magnitude (0x8000 is +1.0) |
| in_a | input | LANES×16 | First operands, lane k in bits 16k+15..16k |
| in_b | input | LANES×16 | Second operands, same lane layout |
| out_valid | output | 1 | Registered results valid |
| out_y | output | LANES×16 | Registered rounded upper halves, same lane layout |

## Verification
- **Corner values.** Every pairing of 0x0000, 0x4000, 0x7FFF and 0x8000 is sent in both modes. This separates the rounding constant, the wrap versus clamp choice on −1 × −1, and the sign correction of magnitude mode. Two instances run side by side, one built with clamping and one with wrapping.
- **Random operands.** Long random runs with a different value in each lane expose lane crosstalk and off-by-one rounding. Magnitude-mode runs draw operands only from 0..0x8000.
- **Back-to-back beats.** The same operands are sent with alternating modes to show that the mode stays with its beat.
- **Idle cycles.** Cycles with changing operands but no valid show that the outputs hold.

// File: rtl/q15_pkg.sv
package q15_pkg;

  // Word and product widths
  localparam int QW = 16;
  localparam int PW = 2 * QW;

  typedef logic signed [QW-1:0] q15_t;
  typedef logic signed [PW-1:0] q15_prod_t;

  // Code with only the sign bit set, and the largest positive code
  localparam q15_t Q_NEG_ONE = {1'b1, {(QW-1){1'b0}}};
  localparam q15_t Q_MAX     = {1'b0, {(QW-1){1'b1}}};

  // Full-width signed product
  function automatic q15_prod_t q_mul(input q15_t a, input q15_t b);
    return q15_prod_t'(a) * q15_prod_t'(b);
  endfunction

  // Add half an LSB of the result, shift arithmetically, keep the low word
  function automatic q15_t q_round_hi(input q15_prod_t p);
    q15_prod_t s;
    s = p + (q15_prod_t'(1) <<< (QW - 2));
    return q15_t'(s >>> (QW - 1));
  endfunction

  // Two's-complement absolute value; the sign-only code maps to itself
  function automatic q15_t q_abs(input q15_t v);
    return v[QW-1] ? q15_t'(-v) : v;
  endfunction

endpackage

// File: rtl/q15_lane.sv
module q15_lane
  import q15_pkg::*;
#(
  parameter bit SAT_SQ = 1'b0
) (
  input  q15_t a,
  input  q15_t b,
  input  logic mode,
  output q15_t y,
  output logic sq_hit
);

  q15_t raw;

  always_comb begin
    sq_hit = (a == Q_NEG_ONE) && (b == Q_NEG_ONE);
    raw    = q_round_hi(q_mul(a, b));
    if (mode) begin
      y = q_abs(raw);
    end else if (SAT_SQ && sq_hit) begin
      y = Q_MAX;
    end else begin
      y = raw;
    end
  end

endmodule

// File: rtl/q15_stage.sv
module q15_stage #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/q15_mulhr_array.sv
module q15_mulhr_array
  import q15_pkg::*;
#(
  parameter int LANES  = 4,
  parameter bit SAT_SQ = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_mode,
  input  logic [LANES*QW-1:0]   in_a,
  input  logic [LANES*QW-1:0]   in_b,
  output logic                  out_valid,
  output logic [LANES*QW-1:0]   out_y
);

  localparam int VW = LANES * QW;

  // Internal events, brought out by name for the checker
  logic             beat_accept;
  logic [LANES-1:0] lane_sq_hit;
  logic [VW-1:0]    lane_y;

  assign beat_accept = in_valid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    q15_lane #(
      .SAT_SQ(SAT_SQ)
    ) u_lane (
      .a      (in_a[g*QW +: QW]),
      .b      (in_b[g*QW +: QW]),
      .mode   (in_mode),
      .y      (lane_y[g*QW +: QW]),
      .sq_hit (lane_sq_hit[g])
    );
  end

  q15_stage #(
    .WIDTH(VW)
  ) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (beat_accept),
    .d     (lane_y),
    .q     (out_y)
  );

  q15_stage #(
    .WIDTH(1)
  ) u_vld (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (in_valid),
    .q     (out_valid)
  );

endmodule

// File: rtl/q15_mulhr_chk.sv
module q15_mulhr_chk
  import q15_pkg::*;
#(
  parameter int LANES  = 4,
  parameter bit SAT_SQ = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_mode,
  input logic [LANES*QW-1:0] in_a,
  input logic [LANES*QW-1:0] in_b,
  input logic                out_valid,
  input logic [LANES*QW-1:0] out_y,
  input logic [LANES-1:0]    lane_sq_hit,
  input logic                beat_accept
);

  // Properties of the beat now shown at the outputs
  logic             mode_q;
  logic [LANES-1:0] sq_q;
  logic [LANES-1:0] zero_q;
  logic [LANES-1:0] zero_now;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      zero_now[k] = (in_a[k*QW +: QW] == '0) || (in_b[k*QW +: QW] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sq_q   <= '0;
      zero_q <= '0;
    end else if (beat_accept) begin
      mode_q <= in_mode;
      sq_q   <= lane_sq_hit;
      zero_q <= zero_now;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_y));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R3
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && zero_q[g]) |-> (out_y[g*QW +: QW] == '0));

    // R5
    neg_one_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sq_q[g] && !mode_q) |->
        (out_y[g*QW +: QW] == (SAT_SQ ? Q_MAX : Q_NEG_ONE)));

    // R7
    mag_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sq_q[g] && mode_q) |-> (out_y[g*QW +: QW] == Q_NEG_ONE));

    // R6
    mag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode_q) |->
        (!out_y[g*QW + QW - 1] || (out_y[g*QW +: QW] == Q_NEG_ONE)));
  end

endmodule

bind q15_mulhr_array q15_mulhr_chk #(
  .LANES  (LANES),
  .SAT_SQ (SAT_SQ)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_mode     (in_mode),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_y       (out_y),
  .lane_sq_hit (lane_sq_hit),
  .beat_accept (beat_accept)
);

// File: tb/sim_q15_mulhr_array.sv
`timescale 1ns/1ps
module sim_q15_mulhr_array;

  localparam int L  = 4;
  localparam int VW = L * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_mode = 1'b0;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic          out_valid, out_valid_s;
  logic [VW-1:0] out_y, out_y_s;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  q15_mulhr_array #(.LANES(L), .SAT_SQ(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_y(out_y));

  q15_mulhr_array #(.LANES(L), .SAT_SQ(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid_s), .out_y(out_y_s));

  // Reference for one lane: integer floor division, then optional magnitude
  function automatic logic [15:0] ref_lane(input logic mode, input logic [15:0] a,
                                           input logic [15:0] b, input logic sat);
    longint sa, sb, num, flo, rem;
    logic [15:0] r;
    sa  = (a >= 16'h8000) ? longint'(a) - 65536 : longint'(a);
    sb  = (b >= 16'h8000) ? longint'(b) - 65536 : longint'(b);
    num = sa * sb + 16384;
    rem = ((num % 32768) + 32768) % 32768;
    flo = (num - rem) / 32768;
    r   = flo[15:0];
    if (mode) begin
      if (r >= 16'h8000 && r != 16'h8000) r = 16'(65536 - int'(r));
    end else if (sat && a == 16'h8000 && b == 16'h8000) begin
      r = 16'h7FFF;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic mode, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b, input logic sat);
    logic [VW-1:0] v;
    for (int k = 0; k < L; k++) v[k*16 +: 16] = ref_lane(mode, a[k*16 +: 16], b[k*16 +: 16], sat);
    return v;
  endfunction

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Send one beat, then check both instances one clock later
  task automatic beat(input string req, input logic mode, input logic [VW-1:0] a,
                      input logic [VW-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0; in_a = ~a; in_b = ~b; in_mode = ~mode;
    check_bit({req, " R2 valid"}, out_valid, 1'b1);
    check_vec({req, " wrap"}, out_y, ref_vec(mode, a, b, 1'b0));
    check_vec({req, " clamp"}, out_y_s, ref_vec(mode, a, b, 1'b1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_bit("R1 valid in reset", out_valid, 1'b0);
    check_vec("R1 data in reset", out_y, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 valid after release", out_valid, 1'b0);
    check_vec("R1 data after release", out_y, '0);
  endtask

  task automatic t_named();
    // lanes: 8000*4000, 7FFF*7FFF, 8000*8000, 0000*7FFF
    logic [VW-1:0] a, b;
    a = {16'h0000, 16'h8000, 16'h7FFF, 16'h8000};
    b = {16'h7FFF, 16'h8000, 16'h7FFF, 16'h4000};
    beat("R4 named signed", 1'b0, a, b);
    check_vec("R4 minus-half and R3 zero", {out_y[63:48], out_y[31:0]}, {16'h0000, 16'h7FFE, 16'hC000});
    check_vec("R5 wrap default", VW'(out_y[47:32]), VW'(16'h8000));
    check_vec("R5 clamp option", VW'(out_y_s[47:32]), VW'(16'h7FFF));
    beat("R6 named magnitude", 1'b1, a, b);
    check_vec("R6 plus-half", VW'(out_y[15:0]), VW'(16'h4000));
    check_vec("R7 unity wrap build", VW'(out_y[47:32]), VW'(16'h8000));
    check_vec("R7 unity clamp build", VW'(out_y_s[47:32]), VW'(16'h8000));
  endtask

  task automatic t_corners();
    logic [15:0] cv [4];
    cv[0] = 16'h0000; cv[1] = 16'h4000; cv[2] = 16'h7FFF; cv[3] = 16'h8000;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 4; i++) begin
        logic [VW-1:0] a, b;
        for (int k = 0; k < 4; k++) begin
          a[k*16 +: 16] = cv[i];
          b[k*16 +: 16] = cv[k];
        end
        beat(m ? "R6 R7 corners" : "R3 R5 corners", m[0], a, b);
      end
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [VW-1:0] a, b;
      logic m;
      m = n[0];
      for (int k = 0; k < L; k++) begin
        if (m) begin
          a[k*16 +: 16] = 16'($urandom_range(0, 32768));
          b[k*16 +: 16] = 16'($urandom_range(0, 32768));
        end else begin
          a[k*16 +: 16] = 16'($urandom);
          b[k*16 +: 16] = 16'($urandom);
        end
      end
      beat(m ? "R6 random" : "R3 random", m, a, b);
    end
  endtask

  task automatic t_hold();
    logic [VW-1:0] keep;
    beat("R9 setup", 1'b0, {4{16'h6000}}, {4{16'h5000}});
    keep = out_y;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_a = {4{16'h8000}}; in_b = {4{16'h1234 + 16'(i)}}; in_mode = i[0];
      check_bit("R2 idle valid low", out_valid, 1'b0);
      check_vec("R9 hold while idle", out_y, keep);
    end
  endtask

  task automatic t_mode_stream();
    logic [VW-1:0] a, b;
    logic m;
    a = {4{16'h8000}}; b = {16'h4000, 16'h2000, 16'h7FFF, 16'h0001};
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b0; in_a = a; in_b = b;
    for (int i = 1; i <= 6; i++) begin
      m = in_mode;
      @(negedge clk);
      check_bit("R8 stream valid", out_valid, 1'b1);
      check_vec("R8 mode follows beat", out_y, ref_vec(m, a, b, 1'b0));
      in_mode = ~in_mode;
      if (i == 6) in_valid = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_named();
    t_corners();
    t_random();
    t_hold();
    t_mode_stream();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule